// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a byte stream of run-length codes into the serial bit stream that loads a programmable-logic device. Bytes enter over a valid/ready port; single bits leave over a second valid/ready port that feeds the configuration shifter one bit per accepted transfer. Pin-level programming timing and the device's status handshake are handled elsewhere.

The block starts out hunting for a start marker in the byte stream. The marker is a 0xFF byte followed directly by a byte whose upper four bits are 0x3. Once the marker is found, the block sends a fixed 16-bit header. It then decodes every following byte as one run-length code until it has handled a byte that carries the last flag. After that it goes back to hunting for the next image. One parameter, the longest run of ones (226 by default), sets where the boundaries between the code ranges fall.

Top module: `rlbd_decomp`

## Requirements
- R1: While hunting, every input byte is accepted (`in_ready` high) and no bit is emitted. The marker is 0xFF immediately followed by a byte whose bits [7:4] equal 4'h3. A lone 0x3X byte, or 0xFF followed by any other value, is not a marker. A run such as FF FF 3X does count as a marker. Neither marker byte is decoded.
- R2: After the marker, the 16 bits of 0xFF20 leave most significant bit first, ahead of any decoded bit. No input byte is accepted while the header is being sent.
- R3: A code c with 1 ≤ c ≤ 226 emits c one-bits followed by one zero-bit.
- R4: Code 227 emits 226 one-bits and no closing zero.
- R5: A code c with 228 ≤ c ≤ 254 emits (c − 228) zero-bits followed by one one-bit, so code 228 emits a single one.
- R6: Code 255 emits exactly one one-bit.
- R7: Code 0 emits nothing and is consumed.
- R8: The next byte is not accepted until every bit of the current code has been taken. While `bit_valid` is high and `bit_ready` is low, the output holds its value.
- R9: `bit_last` is high only on the final bit of a byte that arrived with `in_last` set. Once that bit is taken, the block returns to hunting.
- R10: After a synchronous active-low reset, the block is hunting, with `in_ready` high and `bit_valid` low.
- R11: A code 0 byte that carries `in_last` emits no bit and returns the block to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of an image |
| in_ready | output | 1 | Block accepts the input byte |
| bit_valid | output | 1 | Output bit valid |
| bit_data | output | 1 | Output bit |
| bit_last | output | 1 | Final bit of the image |
| bit_ready | input | 1 | Downstream takes the bit |

## Verification
The first image puts decoy bytes ahead of the marker (a lone 0x37, and 0xFF followed by 0x25). This shows whether the hunter matches on the byte pair rather than on either byte alone. The code table then covers both edges of each range: 1, 5, 226, 227, 228, 229, 254, 255, 0 and 100. This separates an off-by-one in the run length from a missing or extra closing bit. The second image starts with a double 0xFF before its marker. It then stalls the bit output, first completely and then every third cycle, to show that input is held back while a run drains. It ends on an empty code carrying the last flag, which tests the return to hunting when no bit is emitted.

// File: rtl/rlbd_pkg.sv
// Shared types for the run-length configuration bit expander.
package rlbd_pkg;

    localparam int CODE_W = 8;

    // Phases of the expander: hunt for marker, send header, decode codes.
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_HEADER = 2'd1,
        ST_DATA   = 2'd2
    } rlbd_state_e;

    // One decoded code: a run of identical bits, optionally closed by one bit.
    typedef struct packed {
        logic [CODE_W-1:0] run_len;
        logic              run_bit;
        logic              has_term;
        logic              term_bit;
    } rlbd_code_t;

endpackage

// File: rtl/rlbd_code_decode.sv
// Maps one code byte to a run description.
// Assumes 1 <= MAX_ONES <= 252 so that all four code ranges exist.
module rlbd_code_decode
    import rlbd_pkg::*;
#(
    parameter int MAX_ONES = 226
) (
    input  logic [CODE_W-1:0] code,
    output rlbd_code_t        dec
);
    localparam logic [CODE_W-1:0] ONES_TOP  = CODE_W'(MAX_ONES);
    localparam logic [CODE_W-1:0] OPEN_CODE = CODE_W'(MAX_ONES + 1);
    localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
    localparam logic [CODE_W-1:0] SOLO_ONE  = '1;

    // Range decode of the code byte.
    always_comb begin
        dec = '0;
        if (code == '0) begin
            dec = '0;
        end else if (code <= ONES_TOP) begin
            dec.run_len  = code;
            dec.run_bit  = 1'b1;
            dec.has_term = 1'b1;
            dec.term_bit = 1'b0;
        end else if (code == OPEN_CODE) begin
            dec.run_len  = ONES_TOP;
            dec.run_bit  = 1'b1;
        end else if (code == SOLO_ONE) begin
            dec.has_term = 1'b1;
            dec.term_bit = 1'b1;
        end else begin
            dec.run_len  = code - ZERO_BASE;
            dec.run_bit  = 1'b0;
            dec.has_term = 1'b1;
            dec.term_bit = 1'b1;
        end
    end

endmodule

// File: rtl/rlbd_marker_hunt.sv
// Detects the start marker: a lead byte followed by a byte with a given
// upper nibble. Assumes take is high only when a byte is consumed in hunt.
module rlbd_marker_hunt
    import rlbd_pkg::*;
#(
    parameter logic [CODE_W-1:0]   MARK_LEAD = 8'hFF,
    parameter logic [CODE_W/2-1:0] MARK_NIB  = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              take,
    input  logic [CODE_W-1:0] byte_in,
    output logic              found
);
    logic lead_seen;

    // Remembers whether the previous consumed byte was the lead byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lead_seen <= 1'b0;
        end else if (take) begin
            lead_seen <= (byte_in == MARK_LEAD);
        end
    end

    // Marker completes on the byte after a lead byte.
    always_comb begin
        found = en && take && lead_seen &&
                (byte_in[CODE_W-1:CODE_W/2] == MARK_NIB);
    end

endmodule

// File: rtl/rlbd_header_gen.sv
// Shifts out a fixed header, most significant bit first, while enabled.
// Reloads whenever disabled.
module rlbd_header_gen #(
    parameter int              HDR_W    = 16,
    parameter logic [HDR_W-1:0] HDR_BITS = 16'hFF20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    output logic hdr_bit,
    output logic at_end
);
    localparam int IDX_W = $clog2(HDR_W);

    logic [HDR_W-1:0] shreg;
    logic [IDX_W-1:0] idx;

    // Header shift register and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shreg <= HDR_BITS;
            idx   <= '0;
        end else if (step) begin
            shreg <= {shreg[HDR_W-2:0], 1'b0};
            idx   <= idx + 1'b1;
        end
    end

    // Current header bit and end-of-header flag.
    always_comb begin
        hdr_bit = shreg[HDR_W-1];
        at_end  = (idx == IDX_W'(HDR_W - 1));
    end

endmodule

// File: rtl/rlbd_run_engine.sv
// Holds one decoded code and emits its bits one per step.
// Assumes load and step are never high together.
module rlbd_run_engine
    import rlbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  rlbd_code_t code,
    input  logic       load_last,
    input  logic       step,
    output logic       busy,
    output logic       bit_out,
    output logic       final_bit,
    output logic       last_out
);
    logic [CODE_W-1:0] run_cnt;
    logic              run_bit;
    logic              term_pend;
    logic              term_bit;
    logic              last_q;

    // Run counter and closing-bit state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            run_bit   <= 1'b0;
            term_pend <= 1'b0;
            term_bit  <= 1'b0;
            last_q    <= 1'b0;
        end else if (load) begin
            run_cnt   <= code.run_len;
            run_bit   <= code.run_bit;
            term_pend <= code.has_term;
            term_bit  <= code.term_bit;
            last_q    <= load_last;
        end else if (step) begin
            if (run_cnt != '0) begin
                run_cnt <= run_cnt - 1'b1;
            end else begin
                term_pend <= 1'b0;
            end
        end
    end

    // Present bit, and whether it is the last one of this code.
    always_comb begin
        busy      = (run_cnt != '0) || term_pend;
        bit_out   = (run_cnt != '0) ? run_bit : term_bit;
        final_bit = ((run_cnt == CODE_W'(1)) && !term_pend) ||
                    ((run_cnt == '0) && term_pend);
        last_out  = last_q;
    end

endmodule

// File: rtl/rlbd_decomp.sv
// Run-length configuration bit expander, top level.
// Hunts for a start marker, sends a fixed header, then expands code bytes
// into single bits until a byte flagged last has been emitted.
module rlbd_decomp
    import rlbd_pkg::*;
#(
    parameter int                  MAX_ONES  = 226,
    parameter int                  HDR_W     = 16,
    parameter logic [HDR_W-1:0]    HDR_BITS  = 16'hFF20,
    parameter logic [CODE_W-1:0]   MARK_LEAD = 8'hFF,
    parameter logic [CODE_W/2-1:0] MARK_NIB  = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              bit_valid,
    output logic              bit_data,
    output logic              bit_last,
    input  logic              bit_ready
);
    rlbd_state_e state;
    rlbd_code_t  dec;
    logic in_fire, bit_fire, found;
    logic hdr_bit, hdr_end;
    logic eng_busy, eng_bit, eng_final, eng_last;
    logic in_hunt, in_hdr, in_dat, dec_empty;

    // Phase flags.
    always_comb begin
        in_hunt = (state == ST_HUNT);
        in_hdr  = (state == ST_HEADER);
        in_dat  = (state == ST_DATA);
    end

    rlbd_marker_hunt #(
        .MARK_LEAD (MARK_LEAD),
        .MARK_NIB  (MARK_NIB)
    ) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_hunt),
        .take    (in_fire),
        .byte_in (in_data),
        .found   (found)
    );

    rlbd_header_gen #(
        .HDR_W    (HDR_W),
        .HDR_BITS (HDR_BITS)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_hdr),
        .step    (bit_fire),
        .hdr_bit (hdr_bit),
        .at_end  (hdr_end)
    );

    rlbd_code_decode #(
        .MAX_ONES (MAX_ONES)
    ) u_dec (
        .code (in_data),
        .dec  (dec)
    );

    rlbd_run_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (in_dat && in_fire),
        .code      (dec),
        .load_last (in_last),
        .step      (in_dat && bit_fire),
        .busy      (eng_busy),
        .bit_out   (eng_bit),
        .final_bit (eng_final),
        .last_out  (eng_last)
    );

    // Handshakes on both ports.
    always_comb begin
        in_ready  = in_hunt || (in_dat && !eng_busy);
        in_fire   = in_valid && in_ready;
        bit_valid = in_hdr || (in_dat && eng_busy);
        bit_data  = in_hdr ? hdr_bit : eng_bit;
        bit_last  = in_dat && eng_busy && eng_final && eng_last;
        bit_fire  = bit_valid && bit_ready;
        dec_empty = (dec.run_len == '0) && !dec.has_term;
    end

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            case (state)
                ST_HUNT:   if (found) state <= ST_HEADER;
                ST_HEADER: if (bit_fire && hdr_end) state <= ST_DATA;
                ST_DATA: begin
                    if (in_fire && in_last && dec_empty) state <= ST_HUNT;
                    else if (bit_fire && bit_last) state <= ST_HUNT;
                end
                default:   state <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/rlbd_decomp_chk.sv
// Port-level properties of the expander, bound to every instance.
module rlbd_decomp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_last,
    input logic       in_ready,
    input logic       bit_valid,
    input logic       bit_data,
    input logic       bit_last,
    input logic       bit_ready
);
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data) && $stable(bit_last))) // R8
        else $error("stalled bit changed");

    AST_NO_INPUT_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !in_ready) // R8
        else $error("input accepted while bits pending");

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bit_last |-> bit_valid) // R9
        else $error("last flag without valid bit");

    AST_LAST_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_ready && bit_last) |=> (!bit_valid && in_ready)) // R9
        else $error("no return to hunt after last bit");

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!bit_valid && in_ready)) // R10
        else $error("reset state wrong");

endmodule

bind rlbd_decomp rlbd_decomp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .bit_last  (bit_last),
    .bit_ready (bit_ready)
);

// File: tb/rlbd_decomp_bench.sv
module rlbd_decomp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready, bit_valid, bit_data, bit_last;
    logic       bit_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nbits = 0;
    logic got_bit [0:2047];
    logic got_last[0:2047];
    logic exp_bit [0:2047];
    int   nexp = 0;
    bit   hold_low = 1'b0;
    bit   stall = 1'b0;
    bit   finished = 1'b0;

    // Table: {code, run length, run bit, has closing bit, closing bit}
    localparam int NV = 10;
    localparam logic [18:0] VEC [0:NV-1] = '{
        {8'd1,   8'd1,   1'b1, 1'b1, 1'b0},   // R3 low edge
        {8'd5,   8'd5,   1'b1, 1'b1, 1'b0},   // R3
        {8'd226, 8'd226, 1'b1, 1'b1, 1'b0},   // R3 high edge
        {8'd227, 8'd226, 1'b1, 1'b0, 1'b0},   // R4
        {8'd228, 8'd0,   1'b0, 1'b1, 1'b1},   // R5 low edge
        {8'd229, 8'd1,   1'b0, 1'b1, 1'b1},   // R5
        {8'd254, 8'd26,  1'b0, 1'b1, 1'b1},   // R5 high edge
        {8'd255, 8'd0,   1'b0, 1'b1, 1'b1},   // R6
        {8'd0,   8'd0,   1'b0, 1'b0, 1'b0},   // R7
        {8'd100, 8'd100, 1'b1, 1'b1, 1'b0}    // R3, carries last (R9)
    };

    rlbd_decomp u_rlbd_decomp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_last(bit_last), .bit_ready(bit_ready)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 bit_ready = hold_low ? 1'b0 : (stall ? ((cyc % 3) != 0) : 1'b1);
    end

    always @(negedge clk) begin
        if (rst_n && bit_valid && bit_ready) begin
            got_bit[nbits]  = bit_data;
            got_last[nbits] = bit_last;
            nbits++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic l);
        in_data = b; in_last = l; in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic push(input int n, input logic v);
        for (int i = 0; i < n; i++) begin exp_bit[nexp] = v; nexp++; end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cmp_range(input int base, input int ebase, input int n,
                             input string req, input string what);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (got_bit[base+i] !== exp_bit[ebase+i]) bad++;
        chk(bad == 0, req, what, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, ebase, hv, nl, lpos;
        idle(4);
        @(negedge clk);
        chk(in_ready === 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
        chk(bit_valid === 1'b0, "R10", "bit_valid in reset", int'(bit_valid), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk(in_ready === 1'b1 && bit_valid === 1'b0, "R10", "idle after reset",
            int'(bit_valid), 0);
        @(posedge clk); #1;

        // Image A: decoys, marker, table of codes.
        base = nbits; ebase = nexp;
        send(8'h37, 1'b0); send(8'hFF, 1'b0); send(8'h25, 1'b0);
        idle(3);
        chk(nbits == base, "R1", "bits during hunt", nbits - base, 0);
        send(8'hFF, 1'b0); send(8'h31, 1'b0);
        push(8, 1'b1); push(2, 1'b0); push(1, 1'b1); push(5, 1'b0);
        for (int v = 0; v < NV; v++) begin
            push(int'(VEC[v][10:3]), VEC[v][2]);
            if (VEC[v][1]) push(1, VEC[v][0]);
        end
        for (int v = 0; v < NV; v++) send(VEC[v][18:11], v == NV - 1);
        idle(400);
        hv = 0;
        for (int i = 0; i < 16; i++) hv = (hv << 1) | int'(got_bit[base+i]);
        chk(hv == 32'hFF20, "R2", "header A", hv, 32'hFF20);
        chk(hv == 32'hFF20, "R1", "decoy bytes not taken as marker", hv, 32'hFF20);
        begin
            int gp = base + 16, ep = ebase + 16;
            for (int v = 0; v < NV; v++) begin
                int n = int'(VEC[v][10:3]) + int'(VEC[v][1]);
                string rq = (v == 3) ? "R4" : (v >= 4 && v <= 6) ? "R5" :
                            (v == 7) ? "R6" : (v == 8) ? "R7" : "R3";
                cmp_range(gp, ep, n, rq, $sformatf("code %0d bits", VEC[v][18:11]));
                gp += n; ep += n;
            end
        end
        chk(nbits - base == nexp - ebase, "R7", "stream A length",
            nbits - base, nexp - ebase);
        nl = 0; lpos = -1;
        for (int i = base; i < nbits; i++) if (got_last[i]) begin nl++; lpos = i; end
        chk(nl == 1 && lpos == nbits - 1, "R9", "last flag count/position", nl, 1);
        @(negedge clk);
        chk(in_ready === 1'b1 && bit_valid === 1'b0, "R9", "hunting after last",
            int'(in_ready), 1);
        @(posedge clk); #1;

        // Image B: byte after last ignored, FF FF 3A marker, stalls, empty last.
        base = nbits; ebase = nexp;
        send(8'h05, 1'b0);
        idle(3);
        chk(nbits == base, "R9", "byte after last not decoded", nbits - base, 0);
        send(8'hFF, 1'b0); send(8'hFF, 1'b0); send(8'h3A, 1'b0);
        idle(20);
        hold_low = 1'b1;
        idle(2);
        send(8'd200, 1'b0);
        hv = nbits;
        idle(5);
        @(negedge clk);
        chk(bit_valid === 1'b1 && bit_data === 1'b1, "R8", "held bit while stalled",
            int'(bit_valid), 1);
        chk(in_ready === 1'b0, "R8", "input held back during run", int'(in_ready), 0);
        chk(nbits == hv, "R8", "no bit taken while stalled", nbits - hv, 0);
        @(posedge clk); #1;
        hold_low = 1'b0; stall = 1'b1;
        send(8'd254, 1'b0);
        send(8'd0, 1'b1);
        idle(700);
        push(8, 1'b1); push(2, 1'b0); push(1, 1'b1); push(5, 1'b0);
        push(200, 1'b1); push(1, 1'b0); push(26, 1'b0); push(1, 1'b1);
        cmp_range(base, ebase, 16, "R1", "header B after double lead byte");
        cmp_range(base + 16, ebase + 16, nexp - ebase - 16, "R8", "bits under stall");
        chk(nbits - base == nexp - ebase, "R11", "stream B length",
            nbits - base, nexp - ebase);
        nl = 0;
        for (int i = base; i < nbits; i++) if (got_last[i]) nl++;
        chk(nl == 0, "R11", "no last bit on empty code", nl, 0);
        @(negedge clk);
        chk(in_ready === 1'b1 && bit_valid === 1'b0, "R11", "hunting after empty last",
            int'(in_ready), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule